// File: doc/BRIEF.md
# Push-Button Debouncer

This block turns one mechanically bouncing push-button signal into a clean level. The raw pin is first brought into the clock domain through a short flop chain. A four-state machine then watches it: two resting states (button released, button pressed) and two "settling" states entered when the synchronised input disagrees with the resting level. The output moves to the new level only once the input has agreed with it for a whole settle window. If the input falls back before then, the machine returns to the resting state it came from and the output never moves.

The settle window is counted in ticks. A tick is a one-cycle enable from a small divider, so a long window in real time (for example 16 ms) needs only a narrow counter. Both the divider and the window counter run only in the settling states and are cleared in the resting states. The latency from a clean edge to the output is therefore fixed: it is the synchroniser depth plus STABLE_TICKS × TICK_DIV cycles plus one. The window defaults to 256 ticks of one cycle each, which suits simulation. For a real 16 ms window, choose the two parameters so that their product equals the clock frequency times 16 ms.

Top module: `btn_debounce`

## Requirements
- R1: The machine has exactly four states: released, rising-settle, pressed and falling-settle. `btn_clean` is 1 in pressed and falling-settle and 0 in the other two, and it comes from a register.
- R2: Let T = STABLE_TICKS × TICK_DIV. Edge n=1 is the first rising clock edge that samples a new `btn_raw` level. If the raw input holds that level for at least T+1 edges, `btn_clean` takes the new level right after edge T+SYNC_STAGES+1 and not before.
- R3: The window counter and the tick divider count only in the two settle states and are zero in both resting states. The latency in R2 therefore does not depend on how long the block rested beforehand.
- R4: A new raw level that lasts T edges or fewer never reaches `btn_clean`. Chatter of any pattern is absorbed as long as no single run of the new level lasts more than T edges. After any disagreement the count restarts from zero.
- R5: If the input returns to the resting level while in a settle state, the machine goes back to that resting state and `btn_clean` does not change.
- R6: The window counter advances by one only on a tick. A tick is a one-cycle enable issued once every TICK_DIV cycles of a settle state, and it is issued on every cycle when TICK_DIV is 1.
- R7: A synchronous active-high `rst` puts the machine in the released state with `btn_clean` at 0, whatever `btn_raw` is doing.
- R8: `btn_raw` passes through SYNC_STAGES flops, which reset to 0, before the machine sees it. This adds SYNC_STAGES cycles to the latency in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Asynchronous bouncing button level, 1 = pressed |
| btn_clean | output | 1 | Debounced registered level, 1 = pressed |

## Verification
The bench builds two copies of the block. The first has STABLE_TICKS=8 and TICK_DIV=1 (T=8). The second has STABLE_TICKS=5 and TICK_DIV=4 (T=20), so that the divider path, the tick gating and the clearing of the divider between windows are all exercised. Small windows make it cheap to sweep every pulse length from one cycle up to T+2 in both directions, with varied rest gaps in between. The sweep hits the exact reject/accept boundary at T versus T+1 edges, and every cycle of each pulse is compared against the latency formula. Chatter bursts, including runs that stop one cycle short of acceptance, show that the count restarts. A release from reset with the button already held checks the synchroniser latency.

// File: rtl/db_pkg.sv
`timescale 1ns/1ps
package db_pkg;

  // Resting states differ from their settle states in bit 0; bit 1 is the level shown.
  typedef enum logic [1:0] {
    ST_LOW  = 2'b00,
    ST_RISE = 2'b01,
    ST_HIGH = 2'b10,
    ST_FALL = 2'b11
  } db_state_e;

  function automatic logic is_settling(input db_state_e s);
    return (s == ST_RISE) || (s == ST_FALL);
  endfunction

  function automatic logic shown_level(input db_state_e s);
    return (s == ST_HIGH) || (s == ST_FALL);
  endfunction

endpackage

// File: rtl/db_sync.sv
`timescale 1ns/1ps
module db_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RESET_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RESET_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/db_tick.sv
`timescale 1ns/1ps
module db_tick #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] div_q;

  assign tick = run && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/db_fsm.sv
`timescale 1ns/1ps
module db_fsm
  import db_pkg::*;
#(
  parameter int STABLE_TICKS = 256,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             level,
  input  logic             tick,
  output db_state_e        state,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             clean
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_TICKS - 1);

  db_state_e        nxt;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    unique case (state)
      ST_LOW: begin
        cnt_nxt = '0;
        if (level) nxt = ST_RISE;
      end
      ST_RISE: begin
        if (!level) begin
          nxt     = ST_LOW;
          cnt_nxt = '0;
        end else if (tick) begin
          if (cnt == LAST) begin
            nxt     = ST_HIGH;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
      end
      ST_HIGH: begin
        cnt_nxt = '0;
        if (!level) nxt = ST_FALL;
      end
      ST_FALL: begin
        if (level) begin
          nxt     = ST_HIGH;
          cnt_nxt = '0;
        end else if (tick) begin
          if (cnt == LAST) begin
            nxt     = ST_LOW;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
      end
      default: begin
        nxt     = ST_LOW;
        cnt_nxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LOW;
      cnt   <= '0;
      clean <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
      clean <= shown_level(nxt);
    end
  end

  assign run = is_settling(state);

endmodule

// File: rtl/btn_debounce.sv
`timescale 1ns/1ps
module btn_debounce
  import db_pkg::*;
#(
  parameter int STABLE_TICKS = 256,
  parameter int TICK_DIV     = 1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic btn_clean
);

  localparam int CNT_W = (STABLE_TICKS > 1) ? $clog2(STABLE_TICKS) : 1;

  logic             level_s;
  logic             tick_s;
  logic             run_s;
  db_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  db_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b0)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (btn_raw),
    .q   (level_s)
  );

  db_tick #(
    .DIV (TICK_DIV)
  ) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run_s),
    .tick (tick_s)
  );

  db_fsm #(
    .STABLE_TICKS (STABLE_TICKS),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .level (level_s),
    .tick  (tick_s),
    .state (state_q),
    .cnt   (cnt_q),
    .run   (run_s),
    .clean (btn_clean)
  );

endmodule

// File: rtl/db_checker.sv
`timescale 1ns/1ps
module db_checker
  import db_pkg::*;
#(
  parameter int STABLE_TICKS = 256,
  parameter int CNT_W        = 8
) (
  input logic             clk,
  input logic             rst,
  input db_state_e        state,
  input logic [CNT_W-1:0] cnt,
  input logic             tick,
  input logic             level,
  input logic             clean
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_TICKS - 1);

  AST_LOW_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
    state == ST_LOW |=> (state == ST_LOW) || (state == ST_RISE)); // R1

  AST_HIGH_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
    state == ST_HIGH |=> (state == ST_HIGH) || (state == ST_FALL)); // R1

  AST_RISE_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(clean) |-> ($past(state) == ST_RISE) && $past(tick) && ($past(cnt) == LAST)); // R2

  AST_FALL_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $fell(clean) |-> ($past(state) == ST_FALL) && $past(tick) && ($past(cnt) == LAST)); // R2

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_LOW) || (state == ST_HIGH)) |-> cnt == '0); // R3

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R4

  AST_RISE_ABORT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RISE) && !level |=> (state == ST_LOW) && !clean); // R5

  AST_FALL_ABORT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FALL) && level |=> (state == ST_HIGH) && clean); // R5

  AST_TICK_ONLY_SETTLING: assert property (@(posedge clk) disable iff (rst)
    tick |-> (state == ST_RISE) || (state == ST_FALL)); // R6

  AST_CNT_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RISE) && level && !tick |=> $stable(cnt)); // R6

  AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == ST_LOW) && !clean); // R7

endmodule

bind btn_debounce db_checker #(
  .STABLE_TICKS (STABLE_TICKS),
  .CNT_W        (CNT_W)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .state (state_q),
  .cnt   (cnt_q),
  .tick  (tick_s),
  .level (level_s),
  .clean (btn_clean)
);

// File: tb/btn_debounce_tb.sv
`timescale 1ns/1ps
module btn_debounce_tb;

  localparam int SA = 8, DA = 1;
  localparam int SB = 5, DB = 4;
  localparam int TA = SA * DA;
  localparam int TB = SB * DB;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_a = 1'b1;
  logic raw_b = 1'b0;
  logic out_a, out_b;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #2.5 clk = ~clk;

  btn_debounce #(.STABLE_TICKS(SA), .TICK_DIV(DA), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst(rst), .btn_raw(raw_a), .btn_clean(out_a));

  btn_debounce #(.STABLE_TICKS(SB), .TICK_DIV(DB), .SYNC_STAGES(SYNC)) u_dut_pre (
    .clk(clk), .rst(rst), .btn_raw(raw_b), .btn_clean(out_b));

  function automatic int tval(input int sel);
    return (sel != 0) ? TB : TA;
  endfunction

  function automatic logic outv(input int sel);
    return (sel != 0) ? out_b : out_a;
  endfunction

  task automatic drive(input int sel, input logic v);
    if (sel != 0) raw_b = v;
    else          raw_a = v;
  endtask

  task automatic check(input int sel, input logic exp, input string tag, input int n);
    checks++;
    if (outv(sel) !== exp) begin
      fails++;
      $display("FAIL %s dut%0d cycle %0d: actual=%b expected=%b", tag, sel, n, outv(sel), exp);
    end
  endtask

  // Bring the block to a resting level v, well past any window.
  task automatic settle(input int sel, input logic v);
    drive(sel, v);
    repeat (tval(sel) + SYNC + 6) @(negedge clk);
    check(sel, v, "R2 settle", 0);
  endtask

  // Hold the opposite level for L edges, then return; compare every cycle (R1 R2 R4 R5 R8).
  task automatic pulse(input int sel, input int len, input logic v);
    int   t;
    logic exp;
    t = tval(sel);
    drive(sel, ~v);
    for (int n = 1; n <= len + t + SYNC + 4; n++) begin
      @(negedge clk);
      exp = ((len > t) && (n >= t + SYNC + 1) && (n <= len + t + SYNC)) ? ~v : v;
      check(sel, exp, (len > t) ? "R1 R2 R8 accept" : "R4 R5 reject", n);
      if (n == len) drive(sel, v);
    end
    // R3: vary the rest gap so a free-running divider would shift the latency
    repeat (3 + (len % 5)) @(negedge clk);
  endtask

  task automatic sweep(input int sel, input logic v);
    for (int len = 1; len <= tval(sel) + 2; len++) pulse(sel, len, v);
  endtask

  // Chatter, then near-miss runs, then a clean edge; output moves from v to ~v only at the end.
  task automatic burst(input int sel, input logic v);
    int t;
    t = tval(sel);
    for (int i = 0; i < 2 * t; i++) begin
      drive(sel, (i % 2 == 0) ? ~v : v);
      @(negedge clk);
      check(sel, v, "R4 chatter", i);
    end
    repeat (t + SYNC + 2) @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      drive(sel, ~v);
      repeat (t) begin
        @(negedge clk);
        check(sel, v, "R4 R5 restart", b);
      end
      drive(sel, v);
      @(negedge clk);
      check(sel, v, "R4 R5 restart", b);
    end
    drive(sel, ~v);
    for (int n = 1; n <= t + SYNC + 4; n++) begin
      @(negedge clk);
      check(sel, (n >= t + SYNC + 1) ? ~v : v, (sel != 0) ? "R2 R3 R6 final" : "R2 final", n);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(0, 1'b0, "R7 in reset", 0);
    check(1, 1'b0, "R7 in reset", 0);
    rst = 1'b0;
    // Button already held on dut0 at release: R7 then R8 latency from the sync reset value
    for (int n = 1; n <= TA + SYNC + 4; n++) begin
      @(negedge clk);
      check(0, (n >= TA + SYNC + 1) ? 1'b1 : 1'b0, "R7 R8 release", n);
      check(1, 1'b0, "R7 idle", n);
    end
    for (int sel = 0; sel < 2; sel++) begin
      settle(sel, 1'b0);
      sweep(sel, 1'b0);
      settle(sel, 1'b1);
      sweep(sel, 1'b1);
      burst(sel, 1'b1);
      burst(sel, 1'b0);
    end
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule